// File: doc/BRIEF.md
# Differential Trace Timestamp Generator

This block sits beside a trace packet stream and measures the time between trace events. A prescaled counter advances while timestamping is enabled. The block emits a delta record, which is the count accumulated since the previous record, whenever one of three events occurs: a packet write that finds the count non-zero, a counter wrap, or a long stretch with no packet writes. After each record the counter starts again from zero. Records leave through a valid/ready handshake, and each one stays on the output until the receiver accepts it.

A second counting mode stands in for a counter driven by the output line's own clock. In this mode the counter advances only while the line is active and is held at zero while the line is idle. Only bus activity produces records in this mode, so the idle timer is switched off. A master enable gates everything. If a trigger fires while the output slot is occupied, it is remembered and issued as soon as the slot frees.

Top module: `trace_delta_stamp`

## Requirements
- R1: `cfg_prescale` sets the count rate. Code 0 ticks every cycle, 1 every 4th, 2 every 16th and 3 every 64th cycle. After the block starts running, the first tick comes on the cycle numbered by the ratio, so n running cycles give floor(n/ratio) ticks.
- R2: A `pkt_wr` cycle emits a record when the count, including that cycle's tick, is non-zero. A `pkt_wr` that finds a zero count emits nothing. The record's `ts_delta` is that count, and `ts_valid` rises on the next cycle.
- R3: When a tick advances the counter past all ones, a record is emitted with `ts_wrap`=1 and `ts_delta`=0.
- R4: In normal mode, every `IDLE_LIMIT`-th consecutive running cycle without `pkt_wr` emits a record. The idle period restarts on each packet write and after each idle record.
- R5: `cfg_alt_mode` has no effect while `cfg_ts_en` is clear.
- R6: In alternate mode (`cfg_alt_mode` and `cfg_ts_en` both set), ticks occur only while `line_active` is high. The counter is cleared while the line is idle, and no idle-period records are produced.
- R7: With `cfg_ts_en` clear, the counter stays at zero and no records are produced.
- R8: `busy` is high while a record is on the output or a trigger is waiting to be issued.
- R9: A record with `ts_valid` high and `ts_ready` low is held, with `ts_delta` and `ts_wrap` unchanged. A trigger that arrives meanwhile is issued in the cycle that `ts_ready` frees the slot. It carries the count up to that cycle.
- R10: Triggers that coincide in one cycle produce a single record, and the counter restarts from zero after each record.
- R11: A cycle in which `cfg_prescale` differs from its value in the previous cycle produces no tick and restarts the divider phase. The next tick comes a full new period later.
- R12: With `cfg_enable` clear, nothing counts and no records are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Master enable |
| cfg_ts_en | input | 1 | Timestamp enable |
| cfg_alt_mode | input | 1 | Line-qualified counting mode |
| cfg_prescale | input | 2 | Count-rate select |
| pkt_wr | input | 1 | A packet entered the trace FIFO this cycle |
| line_active | input | 1 | Output line is carrying data |
| ts_ready | input | 1 | Receiver accepts the current record |
| ts_valid | output | 1 | A record is on the output |
| ts_delta | output | CNT_W | Elapsed ticks since the previous record |
| ts_wrap | output | 1 | Record includes a counter wrap |
| busy | output | 1 | Record held or trigger waiting |

## Verification
The bench builds the block with `CNT_W`=6 and `IDLE_LIMIT`=100. These values bring a counter wrap within 64 cycles and an idle record within 100 cycles, while still leaving room for every prescale ratio to complete at least one full period. The bench sweeps all four prescale codes over several tick counts and checks each result against floor(n/ratio). It also builds timed scenarios for wrap, idle records, the alternate mode, back-pressure with a queued trigger, and a mid-period prescale change. The expected deltas in these scenarios are worked out from cycle numbers.

// File: rtl/tts_pkg.sv
package tts_pkg;
   localparam int DIV_W = 6;

   typedef enum logic [1:0] {
      PS_DIV1  = 2'd0,
      PS_DIV4  = 2'd1,
      PS_DIV16 = 2'd2,
      PS_DIV64 = 2'd3
   } ps_sel_e;

   function automatic logic [DIV_W-1:0] div_last(input logic [1:0] sel);
      case (ps_sel_e'(sel))
         PS_DIV1:  div_last = DIV_W'(0);
         PS_DIV4:  div_last = DIV_W'(3);
         PS_DIV16: div_last = DIV_W'(15);
         default:  div_last = DIV_W'(63);
      endcase
   endfunction
endpackage

// File: rtl/tts_prescaler.sv
module tts_prescaler
   import tts_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic       hold_i,
   input  logic [1:0] sel_i,
   output logic       tick_o
);
   logic [1:0]       sel_q;
   logic [DIV_W-1:0] ph_q;
   logic             sel_chg;

   assign sel_chg = (sel_i != sel_q);
   assign tick_o  = run_i && !hold_i && !sel_chg && (ph_q == div_last(sel_i));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         ph_q  <= '0;
      end else begin
         sel_q <= sel_i;
         if (!run_i || hold_i || sel_chg || tick_o) ph_q <= '0;
         else                                       ph_q <= ph_q + 1'b1;
      end
   end

   AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      sel_chg |=> (ph_q == '0)); // R11
   AST_NO_TICK_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      sel_chg |-> !tick_o); // R11
endmodule

// File: rtl/tts_counter.sv
module tts_counter #(
   parameter int CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             hold_i,
   input  logic             tick_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_next_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;

   assign cnt_next_o = tick_i ? cnt_q + 1'b1 : cnt_q;
   assign wrap_o     = tick_i && (cnt_q == '1);

   always_ff @(posedge clk) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (!run_i || hold_i || clear_i)   cnt_q <= '0;
      else                                    cnt_q <= cnt_next_o;
   end

   AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0)); // R7
   AST_LINE_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && hold_i) |=> (cnt_q == '0)); // R6
   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/tts_idle_timer.sv
module tts_idle_timer #(
   parameter int LIMIT = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic act_i,
   output logic fire_o
);
   localparam int IW = $clog2(LIMIT + 2);

   generate
      if (LIMIT == 0) begin : g_off
         assign fire_o = 1'b0;
      end else begin : g_on
         logic [IW-1:0] idle_q;
         assign fire_o = arm_i && !act_i && (idle_q == IW'(LIMIT - 1));

         always_ff @(posedge clk) begin
            if (!rst_n)                            idle_q <= '0;
            else if (!arm_i || act_i || fire_o)    idle_q <= '0;
            else                                   idle_q <= idle_q + 1'b1;
         end

         if (LIMIT > 1) begin : g_spacing
            AST_IDLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
               fire_o |=> !fire_o); // R4
         end
         AST_DISARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !arm_i |-> !fire_o); // R6
      end
   endgenerate
endmodule

// File: rtl/tts_emitter.sv
module tts_emitter #(
   parameter int CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             pkt_i,
   input  logic             idle_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] cnt_next_i,
   input  logic             ready_i,
   output logic             valid_o,
   output logic [CNT_W-1:0] delta_o,
   output logic             wrap_o,
   output logic             busy_o,
   output logic             clear_o
);
   logic valid_q, wrapf_q, pend_q, pend_wrap_q;
   logic [CNT_W-1:0] delta_q;
   logic pkt_trig, trig, slot_free, launch;

   assign pkt_trig  = pkt_i && (cnt_next_i != '0);
   assign trig      = pkt_trig || wrap_i || idle_i;
   assign slot_free = !valid_q || ready_i;
   assign launch    = run_i && slot_free && (trig || pend_q);
   assign clear_o   = launch;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         delta_q <= '0;
         wrapf_q <= 1'b0;
      end else if (launch) begin
         valid_q <= 1'b1;
         delta_q <= cnt_next_i;
         wrapf_q <= wrap_i || pend_wrap_q;
      end else if (ready_i) begin
         valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i || launch) begin
         pend_q      <= 1'b0;
         pend_wrap_q <= 1'b0;
      end else if (trig) begin
         pend_q      <= 1'b1;
         pend_wrap_q <= pend_wrap_q || wrap_i;
      end
   end

   assign valid_o = valid_q;
   assign delta_o = delta_q;
   assign wrap_o  = wrapf_q;
   assign busy_o  = valid_q || pend_q;

   AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(delta_o) && $stable(wrap_o))); // R9
   AST_BUSY_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> busy_o); // R8
   AST_QUEUED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && pend_q && ready_i) |=> valid_o); // R9
endmodule

// File: rtl/trace_delta_stamp.sv
module trace_delta_stamp #(
   parameter int CNT_W      = 28,
   parameter int IDLE_LIMIT = 2000000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_enable,
   input  logic             cfg_ts_en,
   input  logic             cfg_alt_mode,
   input  logic [1:0]       cfg_prescale,
   input  logic             pkt_wr,
   input  logic             line_active,
   input  logic             ts_ready,
   output logic             ts_valid,
   output logic [CNT_W-1:0] ts_delta,
   output logic             ts_wrap,
   output logic             busy
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (IDLE_LIMIT < 0) begin : g_bad_idle
         $error("IDLE_LIMIT must not be negative");
      end
   endgenerate

   logic run, alt, line_hold, idle_arm, pkt_g;
   logic tick, wrap, idle_fire, clear;
   logic [CNT_W-1:0] cnt_next;

   assign run       = cfg_enable && cfg_ts_en;
   assign alt       = run && cfg_alt_mode;
   assign line_hold = alt && !line_active;
   assign idle_arm  = run && !alt;
   assign pkt_g     = run && pkt_wr;

   tts_prescaler i_prescaler (
      .clk(clk), .rst_n(rst_n), .run_i(run), .hold_i(line_hold),
      .sel_i(cfg_prescale), .tick_o(tick)
   );

   tts_counter #(.CNT_W(CNT_W)) i_counter (
      .clk(clk), .rst_n(rst_n), .run_i(run), .hold_i(line_hold),
      .tick_i(tick), .clear_i(clear), .cnt_next_o(cnt_next), .wrap_o(wrap)
   );

   tts_idle_timer #(.LIMIT(IDLE_LIMIT)) i_idle (
      .clk(clk), .rst_n(rst_n), .arm_i(idle_arm), .act_i(pkt_g), .fire_o(idle_fire)
   );

   tts_emitter #(.CNT_W(CNT_W)) i_emitter (
      .clk(clk), .rst_n(rst_n), .run_i(run), .pkt_i(pkt_g), .idle_i(idle_fire),
      .wrap_i(wrap), .cnt_next_i(cnt_next), .ready_i(ts_ready),
      .valid_o(ts_valid), .delta_o(ts_delta), .wrap_o(ts_wrap),
      .busy_o(busy), .clear_o(clear)
   );

   AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_enable && !ts_valid) |=> !ts_valid); // R12
   AST_TS_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ts_en && !ts_valid) |=> !ts_valid); // R7
   AST_ALT_NEEDS_TS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_alt_mode && !cfg_ts_en && !ts_valid) |=> (!ts_valid && !busy)); // R5
endmodule

// File: tb/test_trace_delta_stamp.sv
module test_trace_delta_stamp;
   localparam int CLK_P = 10;
   localparam int CW    = 6;
   localparam int IDLE  = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, tsen = 1'b0, alt = 1'b0, pkt = 1'b0, line = 1'b0, rdy = 1'b1;
   logic [1:0] ps = 2'd0;
   logic vld, wrp, bsy;
   logic [CW-1:0] dlt;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   trace_delta_stamp #(.CNT_W(CW), .IDLE_LIMIT(IDLE)) i_trace_delta_stamp (
      .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_ts_en(tsen),
      .cfg_alt_mode(alt), .cfg_prescale(ps), .pkt_wr(pkt), .line_active(line),
      .ts_ready(rdy), .ts_valid(vld), .ts_delta(dlt), .ts_wrap(wrp), .busy(bsy)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pkt_at(input int n);
      if (n > 1) cyc(n - 1);
      pkt = 1'b1;
      cyc(1);
      pkt = 1'b0;
   endtask

   task automatic fresh(input logic [1:0] ps_v, input logic alt_v,
                        input logic line_v, input logic rdy_v);
      en = 1'b0; tsen = 1'b0; rdy = 1'b1; pkt = 1'b0;
      cyc(2);
      ps = ps_v; alt = alt_v; line = line_v;
      cyc(1);
      en = 1'b1; tsen = 1'b1; rdy = rdy_v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      cyc(3);
      chk("reset valid", int'(vld), 0);
      chk("reset busy R8", int'(bsy), 0);
      rst_n = 1'b1;
      cyc(1);

      // R1 sweep over all prescale codes
      for (int p = 0; p < 4; p++) begin
         for (int k = 1; k <= ((p == 3) ? 1 : 3); k++) begin
            int r;
            r = 1 << (2 * p);
            fresh(2'(p), 1'b0, 1'b0, 1'b1);
            pkt_at(k * r + r / 2);
            chk("R1 valid", int'(vld), 1);
            chk("R1 delta", int'(dlt), k);
         end
      end

      // R2 zero count: no record
      fresh(2'd3, 1'b0, 1'b0, 1'b1);
      pkt_at(1);
      chk("R2 zero count", int'(vld), 0);
      fresh(2'd0, 1'b0, 1'b0, 1'b1);
      pkt_at(3);
      chk("R2 nonzero count", int'(dlt), 3);

      // R3 overflow
      fresh(2'd0, 1'b0, 1'b0, 1'b1);
      cyc(63);
      chk("R3 before wrap", int'(vld), 0);
      cyc(1);
      chk("R3 wrap valid", int'(vld), 1);
      chk("R3 wrap flag", int'(wrp), 1);
      chk("R3 wrap delta", int'(dlt), 0);
      cyc(1);
      chk("R3 drained", int'(vld), 0);

      // R10 merge of packet and wrap
      fresh(2'd0, 1'b0, 1'b0, 1'b1);
      pkt_at(64);
      chk("R10 merged wrap", int'(wrp), 1);
      chk("R10 merged delta", int'(dlt), 0);
      cyc(1);
      chk("R10 single record", int'(vld), 0);

      // R10 restart
      fresh(2'd0, 1'b0, 1'b0, 1'b1);
      pkt_at(5);
      chk("R10 first", int'(dlt), 5);
      pkt_at(7);
      chk("R10 restart delta", int'(dlt), 7);

      // R4 idle records
      fresh(2'd3, 1'b0, 1'b0, 1'b1);
      cyc(99);
      chk("R4 before idle", int'(vld), 0);
      cyc(1);
      chk("R4 idle valid", int'(vld), 1);
      chk("R4 idle delta", int'(dlt), 1);
      chk("R4 idle wrap", int'(wrp), 0);
      cyc(99);
      chk("R4 second before", int'(vld), 0);
      cyc(1);
      chk("R4 second valid", int'(vld), 1);
      chk("R4 second delta", int'(dlt), 2);

      // R6 alternate mode
      fresh(2'd0, 1'b1, 1'b0, 1'b1);
      cyc(150);
      chk("R6 no idle record", int'(vld), 0);
      pkt_at(1);
      chk("R6 line idle pkt", int'(vld), 0);
      line = 1'b1;
      pkt_at(10);
      chk("R6 active delta", int'(dlt), 10);
      line = 1'b0;
      cyc(3);
      line = 1'b1;
      pkt_at(4);
      chk("R6 cleared while idle", int'(dlt), 4);

      // R5 alternate bit without timestamp enable
      fresh(2'd0, 1'b1, 1'b1, 1'b1);
      tsen = 1'b0;
      for (int i = 0; i < 5; i++) begin
         pkt_at(24);
         chk("R5 no record", int'(vld), 0);
         chk("R5 not busy", int'(bsy), 0);
      end

      // R7 timestamps off, normal mode, past idle limit
      alt = 1'b0;
      for (int i = 0; i < 5; i++) begin
         pkt_at(30);
         chk("R7 no record", int'(vld), 0);
      end

      // R12 master enable clear
      en = 1'b0; tsen = 1'b1;
      for (int i = 0; i < 5; i++) begin
         pkt_at(30);
         chk("R12 no record", int'(vld), 0);
      end

      // R8 / R9 back-pressure with queued trigger
      fresh(2'd0, 1'b0, 1'b0, 1'b0);
      pkt_at(5);
      chk("R9 held valid", int'(vld), 1);
      chk("R9 held delta", int'(dlt), 5);
      chk("R8 busy", int'(bsy), 1);
      cyc(2);
      chk("R9 still held", int'(dlt), 5);
      pkt_at(2);
      chk("R9 queued keeps old", int'(dlt), 5);
      chk("R8 busy queued", int'(bsy), 1);
      cyc(2);
      rdy = 1'b1;
      cyc(1);
      chk("R9 queued issued", int'(vld), 1);
      chk("R9 queued delta", int'(dlt), 7);
      cyc(1);
      chk("R8 idle after drain", int'(bsy), 0);

      // R11 prescale change restarts phase
      fresh(2'd1, 1'b0, 1'b0, 1'b1);
      cyc(6);
      ps = 2'd2;
      cyc(1);
      pkt_at(15);
      chk("R11 delta before tick", int'(dlt), 1);
      pkt_at(1);
      chk("R11 tick one period later", int'(dlt), 1);
      chk("R11 valid", int'(vld), 1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule